// File: doc/BRIEF.md
# Multiphase Current Balancing Adjuster

This block evens out the load among several power-stage phases that feed one voltage rail from a single compensator. Each time a fresh set of current samples arrives, it looks at the phases that belong to the rail, picks the one carrying the most current and the one carrying the least, and moves a fixed amount of adjustment from the first to the second. Each phase keeps its own adjustment term. The sum of all terms stays the same, so the total commanded pulse width stays the same while the share moves toward the lightly loaded phase.

Each adjustment is added to the shared ramp threshold to give that phase's own pulse-width threshold, which the PWM stage uses downstream. Transfers are trimmed so that no adjustment goes below zero or above the largest value a term can hold. Because of this, every phase always keeps a non-negative duty command. A rail mask selects the phases that take part. A deadband stops transfers when the phases are already close enough to balanced.

Top module: `phase_balance`

## Requirements
- R1: When fewer than two bits of `rail_mask` are set, an update changes no adjustment, and every `thresh_out` field equals `ramp_thresh`.
- R2: The highest and lowest current are searched only among phases whose mask bit is 1. A phase whose mask bit is 0 never changes its adjustment.
- R3: A transfer subtracts an amount from the highest-current phase's adjustment and adds the same amount to the lowest-current phase's adjustment. The sum of all adjustments is unchanged. The nominal amount is `step`.
- R4: With two or more phases enabled, `thresh_out` field i (bits [16*i+15:16*i]) equals `ramp_thresh` plus adjustment i, saturated at 16'hFFFF, one clock after the adjustment settles.
- R5: If the donor adjustment is smaller than `step`, the amount is its whole remaining value. The donor then settles at 0 and never goes negative.
- R6: If the receiving adjustment would pass 16'hFFFF, the amount is cut to the room left, so the receiver stops at 16'hFFFF.
- R7: When currents tie, the lowest phase index wins the highest selection and also the lowest selection.
- R8: No transfer happens when the highest current minus the lowest current is below `deadband`, or when the two are equal. A difference equal to `deadband` does transfer.
- R9: Adjustments change only on a clock edge where `sample_valid` is 1, and they show the result on `adj_out` right after that edge.
- R10: While `rst_n` is low at a clock edge, every adjustment loads `start_adj`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe: the current samples are new |
| rail_mask | input | 4 | Bit i = 1 means phase i is on the rail |
| cur_in | input | 48 | Unsigned 12-bit current of phase i at bits [12*i+11:12*i] |
| ramp_thresh | input | 16 | Shared ramp threshold |
| step | input | 16 | Nominal transfer amount per update |
| deadband | input | 12 | Smallest current spread that causes a transfer |
| start_adj | input | 16 | Adjustment value loaded during reset |
| adj_out | output | 64 | Adjustment of phase i at bits [16*i+15:16*i] |
| thresh_out | output | 64 | Threshold of phase i at bits [16*i+15:16*i] |

## Verification
The current patterns place the maximum and the minimum on different phases. This shows whether the block decodes the right donor and the right receiver, and not only the right amount. Some patterns put the lowest current on a masked-out phase, which separates a search limited to the rail from a search over all phases. Equal-value patterns at the top and at the bottom show how ties are broken. Spreads just below and exactly at the deadband locate the comparison boundary. Repeated updates from a small or a large starting adjustment drive the donor down to zero and the receiver up to full scale.

// File: rtl/phase_balance.sv
`timescale 1ns/1ps
module phase_balance #(
  parameter int N  = 4,
  parameter int CW = 12,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_valid,
  input  logic [N-1:0]    rail_mask,
  input  logic [N*CW-1:0] cur_in,
  input  logic [AW-1:0]   ramp_thresh,
  input  logic [AW-1:0]   step,
  input  logic [CW-1:0]   deadband,
  input  logic [AW-1:0]   start_adj,
  output logic [N*AW-1:0] adj_out,
  output logic [N*AW-1:0] thresh_out
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int SW = AW + IW + 1;
  localparam logic [AW-1:0] MAXV = {AW{1'b1}};

  logic [AW-1:0] adj_q [N];
  logic [AW-1:0] thr_q [N];
  logic [IW-1:0] hi_idx, lo_idx;
  logic [CW-1:0] hi_val, lo_val;
  logic          multi, go;
  logic [AW-1:0] give, room, amt;
  logic [SW-1:0] adj_sum;

  assign multi = $countones(rail_mask) >= 2;

  always_comb begin
    logic found;
    found  = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    hi_val = '0;
    lo_val = '0;
    for (int i = 0; i < N; i++) begin
      if (rail_mask[i]) begin
        if (!found) begin
          found  = 1'b1;
          hi_idx = IW'(i);
          lo_idx = IW'(i);
          hi_val = cur_in[i*CW +: CW];
          lo_val = cur_in[i*CW +: CW];
        end else begin
          if (cur_in[i*CW +: CW] > hi_val) begin
            hi_idx = IW'(i);
            hi_val = cur_in[i*CW +: CW];
          end
          if (cur_in[i*CW +: CW] < lo_val) begin
            lo_idx = IW'(i);
            lo_val = cur_in[i*CW +: CW];
          end
        end
      end
    end
  end

  assign give = (adj_q[hi_idx] < step) ? adj_q[hi_idx] : step;
  assign room = MAXV - adj_q[lo_idx];
  assign amt  = (give < room) ? give : room;
  assign go   = sample_valid && multi && (hi_val != lo_val) &&
                ((hi_val - lo_val) >= deadband);

  always_comb begin
    adj_sum = '0;
    for (int i = 0; i < N; i++) adj_sum = adj_sum + SW'(adj_q[i]);
  end

  for (genvar g = 0; g < N; g++) begin : g_ph
    logic [AW:0] raw;
    assign raw = {1'b0, ramp_thresh} + {1'b0, adj_q[g]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        adj_q[g] <= start_adj;
      end else if (go && hi_idx == IW'(g)) begin
        adj_q[g] <= adj_q[g] - amt;
      end else if (go && lo_idx == IW'(g)) begin
        adj_q[g] <= adj_q[g] + amt;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)     thr_q[g] <= '0;
      else if (!multi) thr_q[g] <= ramp_thresh;
      else             thr_q[g] <= raw[AW] ? MAXV : raw[AW-1:0];
    end

    assign adj_out[g*AW +: AW]    = adj_q[g];
    assign thresh_out[g*AW +: AW] = thr_q[g];

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_mask[g] |=> $stable(adj_q[g])); // R2
  end

  AST_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> adj_sum == $past(adj_sum)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> adj_out == $past(adj_out)); // R9
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rail_mask) < 2) |=> adj_out == $past(adj_out)); // R1
  AST_SINGLE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rail_mask) < 2) |=> thresh_out == {N{$past(ramp_thresh)}}); // R1
endmodule

// File: tb/phase_balance_tb.sv
`timescale 1ns/1ps
module phase_balance_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sample_valid = 0;
  logic [3:0]  rail_mask = 4'hF;
  logic [47:0] cur_in = '0;
  logic [15:0] ramp_thresh = 16'd2000;
  logic [15:0] step = 16'd100;
  logic [11:0] deadband = 12'd10;
  logic [15:0] start_adj = 16'd1000;
  logic [63:0] adj_out, thresh_out;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  phase_balance u_dut (.clk, .rst_n, .sample_valid, .rail_mask, .cur_in,
    .ramp_thresh, .step, .deadband, .start_adj, .adj_out, .thresh_out);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] q4(int a0, int a1, int a2, int a3);
    return {16'(a3), 16'(a2), 16'(a1), 16'(a0)};
  endfunction

  task automatic do_reset(logic [15:0] s);
    @(negedge clk);
    rst_n = 0; start_adj = s; sample_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic upd(int c0, int c1, int c2, int c3, logic [3:0] m);
    cur_in = {12'(c3), 12'(c2), 12'(c1), 12'(c0)};
    rail_mask = m;
    sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(16'd1000);
    chk("R10 reset adj", adj_out, q4(1000,1000,1000,1000));
    chk("R4 reset thresh", thresh_out, q4(3000,3000,3000,3000));
  endtask

  task automatic t_basic();
    do_reset(16'd1000);
    upd(400, 800, 200, 500, 4'hF);
    chk("R3 basic adj", adj_out, q4(1000,900,1100,1000));
    chk("R4 basic thresh", thresh_out, q4(3000,2900,3100,3000));
  endtask

  task automatic t_idle();
    cur_in = {12'd10, 12'd900, 12'd10, 12'd10};
    repeat (3) @(negedge clk);
    chk("R9 no strobe", adj_out, q4(1000,900,1100,1000));
  endtask

  task automatic t_mask();
    do_reset(16'd1000);
    upd(400, 800, 50, 300, 4'b1011);
    chk("R2 masked phase", adj_out, q4(1000,900,1000,1100));
  endtask

  task automatic t_single();
    do_reset(16'd1000);
    upd(100, 900, 50, 300, 4'b0010);
    chk("R1 single adj", adj_out, q4(1000,1000,1000,1000));
    chk("R1 single thresh", thresh_out, q4(2000,2000,2000,2000));
  endtask

  task automatic t_tie();
    do_reset(16'd1000);
    upd(100, 900, 500, 900, 4'hF);
    chk("R7 tie at top", adj_out, q4(1100,900,1000,1000));
    do_reset(16'd1000);
    upd(500, 100, 100, 300, 4'hF);
    chk("R7 tie at bottom", adj_out, q4(900,1100,1000,1000));
    upd(300, 300, 300, 300, 4'hF);
    chk("R8 all equal", adj_out, q4(900,1100,1000,1000));
  endtask

  task automatic t_deadband();
    do_reset(16'd1000);
    upd(505, 500, 500, 500, 4'hF);
    chk("R8 below deadband", adj_out, q4(1000,1000,1000,1000));
    upd(510, 500, 500, 500, 4'hF);
    chk("R8 at deadband", adj_out, q4(900,1100,1000,1000));
  endtask

  task automatic t_clamp();
    do_reset(16'd150);
    upd(900, 100, 200, 300, 4'hF);
    chk("R3 first step", adj_out, q4(50,250,150,150));
    upd(900, 100, 200, 300, 4'hF);
    chk("R5 partial step", adj_out, q4(0,300,150,150));
    upd(900, 100, 200, 300, 4'hF);
    chk("R5 stays zero", adj_out, q4(0,300,150,150));
  endtask

  task automatic t_sat();
    ramp_thresh = 16'hFFF0;
    do_reset(16'd1000);
    chk("R4 saturation", thresh_out, q4(65535,65535,65535,65535));
    ramp_thresh = 16'd2000;
    step = 16'd10000;
    do_reset(16'd60000);
    upd(900, 100, 0, 0, 4'b0011);
    chk("R6 receiver cap", adj_out, q4(54465,65535,60000,60000));
    step = 16'd100;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_idle();
    t_mask();
    t_single();
    t_tie();
    t_deadband();
    t_clamp();
    t_sat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule